// File: doc/BRIEF.md
# Match-Capture Counter Timer

A general-purpose counter/timer for a microcontroller peripheral set. A prescale stage divides a stream of count ticks, and the main counter advances once each time the prescale stage wraps. Ticks come either from every cycle of the block clock (timer mode) or from rising edges of an external count input (counter mode). Both the counter and the prescaler are `CNT_W` bits wide, with 16 or 32 as the intended values.

Four match channels compare their values against the counter. Each channel can set a sticky interrupt flag. It can also make the counter continue, return to zero or halt, and it drives its own output pin with a keep, low, high or toggle action. A capture channel samples the counter into a capture register on a selected transition of a capture input. Software configures the block through a single-cycle register-write port. It observes the counter, the capture value, the pins and the flags on output ports.

Top module: `mct_timer`

## Requirements
- R1: After reset (rst_n low) the counter, the capture value, every match pin, every flag and irq_o read 0, and the counter is not running.
- R2: The control word is written at address 0: bit0 run, bit1 mode (0 timer, 1 counter), bits[3:2] capture edge, bit4 capture interrupt enable. In timer mode, with run set and prescale value P written at address 2, the counter advances once every P+1 clock cycles.
- R3: In counter mode each rising edge of ext_cnt_i, after a two-flop synchronizer, is one tick, and the clock alone never advances the counter.
- R4: A write to address 1 loads the counter and clears the prescale phase. While run is clear the counter holds its value.
- R5: Match value i is written at address 8+i. The match configuration at address 3 holds five bits per channel at bits [5i+4:5i]: bit0 interrupt enable, bit1 reset, bit2 stop, bits[4:3] pin action. A channel hits at a counter increment where the counter equals its value, and the hit sets flag i when interrupt enable is 1. With neither reset nor stop set, the counter continues to value+1.
- R6: On a hit with reset set, the counter becomes 0 instead of value+1. The matched value is therefore held for one full prescaled tick.
- R7: On a hit with stop set, the counter keeps the matched value and run is cleared.
- R8: When several channels hit together, stop wins over reset and reset wins over continue.
- R9: On a hit, match pin i takes an action set by its code: 00 unchanged, 01 driven low, 10 driven high, 11 toggled.
- R10: The capture edge code 00 is off, 01 rising, 10 falling, 11 both. On a selected edge of the synchronized cap_i, the capture register takes the counter value. Flag 4 is set when capture interrupt enable is 1. Unselected edges change nothing.
- R11: The flags are sticky. Writing address 4 clears each flag whose data bit is 1, and a new set wins over a clear in the same cycle. irq_o is 1 exactly when some flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address |
| wr_data_i | input | DATA_W | Register write data |
| ext_cnt_i | input | 1 | External count input (counter mode) |
| cap_i | input | 1 | Capture input |
| count_o | output | CNT_W | Current counter value |
| cap_o | output | CNT_W | Capture register |
| match_pin_o | output | NUM_MATCH | Match output pins |
| irq_flags_o | output | NUM_MATCH+1 | Sticky flags; bit NUM_MATCH is capture |
| irq_o | output | 1 | OR of all flags |

## Verification
Every cycle, the assertions check four things. The counter only holds, steps by one, returns to zero or takes a loaded value, and it stays frozen while idle. A stop hit clears run and freezes the count, and a pin moves only on its own channel's hit. Flags fall only under a matching clear bit, and the capture register changes only on a capture event, to the previous count. Other behaviour shows only in the bench's scenarios. These cover the exact count reached for each prescale value, and the wrap period and toggle parity of reset matches. They also cover stop-over-reset and reset-over-continue priority, edge counting through the synchronizer, and capture with each edge selection.

// File: rtl/mct_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the match-capture counter timer.
// Assumes the register map below is decoded by the top module only.
package mct_pkg;

    localparam int ADDR_CTRL    = 0;
    localparam int ADDR_LOAD    = 1;
    localparam int ADDR_PRESC   = 2;
    localparam int ADDR_MCFG    = 3;
    localparam int ADDR_CLR     = 4;
    localparam int ADDR_MR_BASE = 8;
    localparam int MCFG_BITS    = 5;

    typedef enum logic [1:0] {
        PIN_KEEP   = 2'b00,
        PIN_LOW    = 2'b01,
        PIN_HIGH   = 2'b10,
        PIN_TOGGLE = 2'b11
    } pin_act_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        pin_act_e pin_act;
        logic     stop;
        logic     rst;
        logic     irq;
    } match_cfg_t;

endpackage

// File: rtl/mct_sync_edge.sv
`timescale 1ns/1ps
// Synchronizes an asynchronous input through STAGES flops and reports
// a selected transition of the synchronized level as a one-cycle pulse.
// Assumes the input stays stable for at least two clock cycles per level.
module mct_sync_edge
    import mct_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      din,
    input  edge_sel_e sel,
    output logic      edge_o
);

    logic [STAGES:0] shf_q;
    logic            lvl;
    logic            prev;

    // Shift the input through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= {shf_q[STAGES-1:0], din};
    end

    assign lvl  = shf_q[STAGES-1];
    assign prev = shf_q[STAGES];

    // Pick the transition the caller asked for.
    always_comb begin
        unique case (sel)
            EDGE_RISE: edge_o = lvl & ~prev;
            EDGE_FALL: edge_o = ~lvl & prev;
            EDGE_BOTH: edge_o = lvl ^ prev;
            default:   edge_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/mct_prescaler.sv
`timescale 1ns/1ps
// Prescale stage: counts ticks and emits an increment pulse on the tick
// where its phase equals the programmed limit, then restarts at zero.
// Assumes the limit is not lowered below the phase while running; if it
// is, the phase runs on to its own wrap before matching again.
module mct_prescaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         inc
);

    logic [W-1:0] phase_q;

    assign inc = tick && (phase_q == limit);

    // Advance or restart the prescale phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) phase_q <= '0;
        else if (inc)      phase_q <= '0;
        else if (tick)     phase_q <= phase_q + 1'b1;
    end

endmodule

// File: rtl/mct_match_unit.sv
`timescale 1ns/1ps
// One match channel: detects equality at a counter increment and drives
// the channel's output pin with the configured action on a hit.
// Assumes the counter-side actions (stop, reset) are resolved by the top.
module mct_match_unit
    import mct_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic [W-1:0] count,
    input  logic [W-1:0] value,
    input  pin_act_e     act,
    output logic         hit,
    output logic         pin_o
);

    assign hit = inc && (count == value);

    // Apply the pin action on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_o <= 1'b0;
        end else if (hit) begin
            unique case (act)
                PIN_LOW:    pin_o <= 1'b0;
                PIN_HIGH:   pin_o <= 1'b1;
                PIN_TOGGLE: pin_o <= ~pin_o;
                default:    pin_o <= pin_o;
            endcase
        end
    end

endmodule

// File: rtl/mct_capture.sv
`timescale 1ns/1ps
// Capture channel: synchronizes the capture input, detects the selected
// edge and stores the counter value on it.
// Assumes the stored value is the count present in the detection cycle.
module mct_capture
    import mct_pkg::*;
#(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_in,
    input  edge_sel_e    sel,
    input  logic [W-1:0] count,
    output logic         evt,
    output logic [W-1:0] cap_q
);

    mct_sync_edge #(.STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (cap_in),
        .sel    (sel),
        .edge_o (evt)
    );

    // Latch the counter on a capture event.
    always_ff @(posedge clk) begin
        if (!rst_n)   cap_q <= '0;
        else if (evt) cap_q <= count;
    end

endmodule

// File: rtl/mct_timer.sv
`timescale 1ns/1ps
// Match-capture counter timer top: register decode, counter with
// prioritized match actions, interrupt flags, match pins and capture.
// Assumes NUM_MATCH*MCFG_BITS and CNT_W fit in DATA_W, NUM_MATCH <= 8.
module mct_timer
    import mct_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int NUM_MATCH   = 4,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic                 ext_cnt_i,
    input  logic                 cap_i,
    output logic [CNT_W-1:0]     count_o,
    output logic [CNT_W-1:0]     cap_o,
    output logic [NUM_MATCH-1:0] match_pin_o,
    output logic [NUM_MATCH:0]   irq_flags_o,
    output logic                 irq_o
);

    localparam int NFLAG = NUM_MATCH + 1;
    localparam int CFG_W = NUM_MATCH * MCFG_BITS;

    logic                 wr_ctrl, wr_load, wr_presc, wr_mcfg, wr_clr;
    logic                 run_q, mode_q, cap_irq_q;
    edge_sel_e            cap_sel_q;
    logic [CNT_W-1:0]     presc_q;
    logic [CFG_W-1:0]     mcfg_q;
    logic [CNT_W-1:0]     mval_q [NUM_MATCH];
    logic [CNT_W-1:0]     count_q;
    logic [NFLAG-1:0]     flags_q;
    logic [NUM_MATCH-1:0] hit, stop_en, rst_en, irq_en;
    logic                 ext_rise, tick, inc, stop_any, rst_any, cap_evt;
    logic [NFLAG-1:0]     flag_set, flag_clr;

    assign wr_ctrl  = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CTRL));
    assign wr_load  = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_LOAD));
    assign wr_presc = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_PRESC));
    assign wr_mcfg  = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_MCFG));
    assign wr_clr   = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CLR));

    // Control word; a stop hit drops run unless software writes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            mode_q    <= 1'b0;
            cap_sel_q <= EDGE_OFF;
            cap_irq_q <= 1'b0;
        end else if (wr_ctrl) begin
            run_q     <= wr_data_i[0];
            mode_q    <= wr_data_i[1];
            cap_sel_q <= edge_sel_e'(wr_data_i[3:2]);
            cap_irq_q <= wr_data_i[4];
        end else if (stop_any) begin
            run_q     <= 1'b0;
        end
    end

    // Prescale limit, match configuration and match values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
            mcfg_q  <= '0;
            for (int i = 0; i < NUM_MATCH; i++) mval_q[i] <= '0;
        end else begin
            if (wr_presc) presc_q <= wr_data_i[CNT_W-1:0];
            if (wr_mcfg)  mcfg_q  <= wr_data_i[CFG_W-1:0];
            for (int i = 0; i < NUM_MATCH; i++) begin
                if (wr_en_i && wr_addr_i == ADDR_W'(ADDR_MR_BASE + i))
                    mval_q[i] <= wr_data_i[CNT_W-1:0];
            end
        end
    end

    mct_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (ext_cnt_i),
        .sel    (EDGE_RISE),
        .edge_o (ext_rise)
    );

    assign tick = run_q && (mode_q ? ext_rise : 1'b1);

    mct_prescaler #(.W(CNT_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .clr   (wr_load),
        .limit (presc_q),
        .inc   (inc)
    );

    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_match
        match_cfg_t cfg;
        assign cfg        = match_cfg_t'(mcfg_q[g*MCFG_BITS +: MCFG_BITS]);
        assign stop_en[g] = cfg.stop;
        assign rst_en[g]  = cfg.rst;
        assign irq_en[g]  = cfg.irq;

        mct_match_unit #(.W(CNT_W)) u_match (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc),
            .count (count_q),
            .value (mval_q[g]),
            .act   (cfg.pin_act),
            .hit   (hit[g]),
            .pin_o (match_pin_o[g])
        );
    end

    assign stop_any = |(hit & stop_en);
    assign rst_any  = |(hit & rst_en);

    // Main counter: load, then stop over reset over continue.
    always_ff @(posedge clk) begin
        if (!rst_n)        count_q <= '0;
        else if (wr_load)  count_q <= wr_data_i[CNT_W-1:0];
        else if (inc) begin
            if (stop_any)     count_q <= count_q;
            else if (rst_any) count_q <= '0;
            else              count_q <= count_q + 1'b1;
        end
    end

    mct_capture #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_in (cap_i),
        .sel    (cap_sel_q),
        .count  (count_q),
        .evt    (cap_evt),
        .cap_q  (cap_o)
    );

    assign flag_set = {cap_evt & cap_irq_q, hit & irq_en};
    assign flag_clr = wr_clr ? wr_data_i[NFLAG-1:0] : '0;

    // Sticky flags: set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | flag_set;
    end

    assign count_o     = count_q;
    assign irq_flags_o = flags_q;
    assign irq_o       = |flags_q;

endmodule

// File: rtl/mct_timer_chk.sv
`timescale 1ns/1ps
// Checker for mct_timer, attached by bind. Observes ports and a few
// internal nets produced by separate pieces of logic.
module mct_timer_chk #(
    parameter int CNT_W     = 32,
    parameter int NUM_MATCH = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en_i,
    input logic [ADDR_W-1:0]    wr_addr_i,
    input logic [DATA_W-1:0]    wr_data_i,
    input logic [CNT_W-1:0]     count_o,
    input logic [CNT_W-1:0]     cap_o,
    input logic [NUM_MATCH-1:0] match_pin_o,
    input logic [NUM_MATCH:0]   irq_flags_o,
    input logic                 run_q,
    input logic                 inc,
    input logic [NUM_MATCH-1:0] hit,
    input logic [NUM_MATCH-1:0] stop_en,
    input logic                 cap_evt
);

    logic                load_w, ctrl_w;
    logic [NUM_MATCH:0]  clr_mask;

    assign load_w   = wr_en_i && (wr_addr_i == ADDR_W'(1));
    assign ctrl_w   = wr_en_i && (wr_addr_i == ADDR_W'(0));
    assign clr_mask = (wr_en_i && wr_addr_i == ADDR_W'(4)) ? wr_data_i[NUM_MATCH:0] : '0;

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !load_w) |=> $stable(count_o));

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_w) |=> (count_o == $past(count_o) ||
                       count_o == CNT_W'($past(count_o) + 1'b1) ||
                       count_o == '0));

    p_stop_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && |(hit & stop_en) && !ctrl_w && !load_w) |=> (!run_q && $stable(count_o)));

    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_pin
        p_pin_on_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit[g]) |=> $stable(match_pin_o[g]));
    end

    p_cap_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_evt) |=> $stable(cap_o));

    p_cap_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_o == $past(count_o)));

    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_flags_o) |=> ((($past(irq_flags_o) & ~$past(clr_mask)) & ~irq_flags_o) == '0));

endmodule

bind mct_timer mct_timer_chk #(
    .CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .count_o     (count_o),
    .cap_o       (cap_o),
    .match_pin_o (match_pin_o),
    .irq_flags_o (irq_flags_o),
    .run_q       (run_q),
    .inc         (inc),
    .hit         (hit),
    .stop_en     (stop_en),
    .cap_evt     (cap_evt)
);

// File: tb/mct_timer_bench.sv
`timescale 1ns/1ps
// Bench for mct_timer: a vector table of match scenarios on channel 0,
// then directed tests for reset, priority, counter mode, capture, flags.
module mct_timer_bench;

    typedef struct packed {
        int   pr;
        int   mv;
        int   cfg;
        int   ticks;
        int   cnt;
        logic flag;
        logic pin;
    } vec_t;

    // cfg bits: 0 irq, 1 reset, 2 stop, 4:3 pin (01 low, 10 high, 11 toggle)
    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{0, 100,  1, 10, 10, 1'b0, 1'b0},   // R2 plain timer
        '{3, 100,  1, 10,  2, 1'b0, 1'b0},   // R2 prescale by 4
        '{0,   5, 27, 14,  2, 1'b1, 1'b0},   // R6 R9 two wraps, toggled twice
        '{0,   5, 27, 18,  0, 1'b1, 1'b1},   // R6 R9 three wraps
        '{0,   7, 13, 20,  7, 1'b1, 1'b0},   // R7 R9 stop, drive low
        '{1,   3, 17, 12,  6, 1'b1, 1'b1},   // R5 R9 continue, drive high
        '{2,   2,  2, 30,  1, 1'b0, 1'b1}    // R6 no irq, pin kept
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        ext_cnt = 1'b0;
    logic        cap_in = 1'b0;
    logic [31:0] count_o, cap_o;
    logic [3:0]  pins;
    logic [4:0]  flags;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    mct_timer u_mct_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .ext_cnt_i   (ext_cnt),
        .cap_i       (cap_in),
        .count_o     (count_o),
        .cap_o       (cap_o),
        .match_pin_o (pins),
        .irq_flags_o (flags),
        .irq_o       (irq)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 32'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Exactly t ticks in timer mode (t >= 2), ending at a negedge.
    task automatic run_ticks(int t);
        wr(0, 1);
        repeat (t - 2) @(negedge clk);
        wr(0, 0);
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL R1 watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        chk("R1", "count", count_o, 0);
        chk("R1", "cap", cap_o, 0);
        chk("R1", "pins", pins, 0);
        chk("R1", "flags", flags, 0);
        chk("R1", "irq", irq, 0);
        wait_n(4);
        chk("R1", "count idle", count_o, 0);

        for (int i = 1; i < 4; i++) wr(8 + i, -1);

        for (int v = 0; v < NVEC; v++) begin
            wr(3, VECS[v].cfg);
            wr(8, VECS[v].mv);
            wr(2, VECS[v].pr);
            wr(1, 0);
            wr(4, 31);
            run_ticks(VECS[v].ticks);
            chk("R2 R5 R6 R7", $sformatf("vec%0d count", v), count_o, VECS[v].cnt);
            chk("R5", $sformatf("vec%0d flag0", v), flags[0], VECS[v].flag);
            chk("R9", $sformatf("vec%0d pin0", v), pins[0], VECS[v].pin);
        end

        // R4: load while stopped, and hold
        wr(1, 55);
        wait_n(5);
        chk("R4", "load and hold", count_o, 55);

        // R8: stop (ch1) beats reset (ch0) at the same value
        wr(2, 0);
        wr(8, 4); wr(9, 4);
        wr(3, 3 | (5 << 5));
        wr(1, 0); wr(4, 31);
        run_ticks(10);
        chk("R8", "stop over reset count", count_o, 4);
        chk("R8", "both flags", flags, 5'b00011);

        // R11: write-one-to-clear per bit and irq OR
        wr(4, 1);
        chk("R11", "clear bit0", flags, 5'b00010);
        chk("R11", "irq with one flag", irq, 1);
        wr(4, 0);
        chk("R11", "zero write keeps", flags, 5'b00010);
        wr(4, 2);
        chk("R11", "clear bit1", flags, 0);
        chk("R11", "irq low", irq, 0);

        // R8: reset (ch0) beats continue (ch1)
        wr(3, 2 | (1 << 5));
        wr(1, 0); wr(4, 31);
        run_ticks(10);
        chk("R8", "reset over continue count", count_o, 0);
        chk("R8", "continue flag only", flags, 5'b00010);

        // R3: counter mode counts synchronized rising edges only
        wr(9, -1); wr(8, -1); wr(3, 0);
        wr(1, 0); wr(4, 31);
        wr(0, 3);
        wait_n(10);
        chk("R3", "clock ignored", count_o, 0);
        for (int p = 0; p < 5; p++) begin
            ext_cnt = 1'b1; wait_n(3);
            ext_cnt = 1'b0; wait_n(3);
        end
        wait_n(6);
        chk("R3", "five edges", count_o, 5);
        wr(0, 0);

        // R10: capture with each edge selection
        wr(1, 123);
        wr(0, (1 << 2) | (1 << 4));
        wr(4, 31);
        cap_in = 1'b1; wait_n(6);
        chk("R10", "rising capture", cap_o, 123);
        chk("R10", "capture flag", flags[4], 1);
        wr(1, 200);
        cap_in = 1'b0; wait_n(6);
        chk("R10", "falling ignored", cap_o, 123);
        wr(0, (3 << 2));
        wr(4, 31);
        cap_in = 1'b1; wait_n(6);
        chk("R10", "both-edge capture", cap_o, 200);
        chk("R10", "flag off when disabled", flags[4], 0);
        wr(1, 77);
        wr(0, (2 << 2));
        cap_in = 1'b0; wait_n(6);
        chk("R10", "falling capture", cap_o, 77);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule